// File: doc/BRIEF.md
# CBC-MAC Engine Control Unit

This block is the control, status and chaining logic for a message-authentication engine that works in cipher-block-chaining MAC mode. Software reaches it through a 32-bit word-addressed register port. Input data reaches it as a stream of 32-bit words from a DMA port. The block packs four words into a 128-bit block. It XORs the block into the running chaining state and hands the result to an external block cipher through a request/acknowledge port. The enciphered value that comes back becomes the new chaining state. When the programmed byte count has been consumed, the final state is the authentication tag, and software reads it as four words.

A message may be authenticated in several calls. Every call except the last must cover a whole number of 16-byte blocks. After a call, software reads the tag and writes it back as the initial vector of the next call. The last call may end part-way through a block; the missing bytes are taken as zero. Key loading is a simple handshake with an external key store: software writes the area number and then polls a busy bit.

Top module: `cbcmac_ctrl`

Register word addresses: 0 path select, 1 key area, 2 interrupt status, 3 interrupt clear, 4 control, 5 length low, 6 length high, 8 to 11 IV words, 12 to 15 tag words. Word k of the IV or tag is bits [32k+31:32k] of the 128-bit state. Stream word k of a block fills bits [32k+31:32k], and its byte i fills bits [8i+7:8i] of that word.

## Requirements
- R1: After reset, interrupt status, control and every tag word read 0, and both `dma_ready` and `ciph_req` are low.
- R2: `dma_ready` can only be high while the path-select register (address 0) holds 0x2. With any other value, a pending run accepts no stream words and does not complete.
- R3: A write to address 1 pulses `key_start` in that same cycle and latches the area from bits [3:0]. Bit 31 at address 1 then reads 1 until `key_done` is seen, and 0 afterwards.
- R4: When `key_done` arrives together with `key_err`, interrupt status bit 29 is set. Writing 1 to bit 29 of address 3 clears it.
- R5: A write to address 6 starts a run over {length-high, length-low} bytes. For each block the state becomes cipher(state XOR block). The tag words read back the final state.
- R6: After a non-final aligned part, writing its tag to addresses 8 to 11 and running the rest gives the same tag as authenticating the whole message in one run.
- R7: In the final part, bytes of the last stream word beyond the programmed length are replaced by zero. Missing words of the last block are also zero before chaining.
- R8: Interrupt status bit 0 sets when a run ends, whether well or with an error. Writing 1 to bit 0 of address 3 clears it.
- R9: Control bit 30 sets when a run ends without error. Reading tag words 12 to 14 leaves it set; reading address 15 clears it.
- R10: If the stream marks its last word (`dma_last`) before the programmed length is reached, the run ends at once. Status bits 31 and 0 are set, control bit 30 stays 0, and `dma_ready` drops.
- R11: If control bit 0 (final part) is 0 and the length is not a multiple of 16, starting sets status bits 31 and 0 without accepting any stream word.
- R12: `dma_ready` is low in every cycle that `ciph_req` is high. `ciph_req` and `ciph_data` hold steady until `ciph_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (tag word 15 has a read side effect) |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| key_start | output | 1 | One-cycle request to the key store |
| key_area | output | AREA_W | Key area being loaded |
| key_done | input | 1 | Key store finished |
| key_err | input | 1 | Key load failed, valid with `key_done` |
| dma_valid | input | 1 | Stream word valid |
| dma_data | input | 32 | Stream word |
| dma_last | input | 1 | Final word of the stream |
| dma_ready | output | 1 | Word accepted when high with `dma_valid` |
| ciph_req | output | 1 | Cipher request |
| ciph_data | output | 128 | State XOR block, sent to the cipher |
| ciph_ack | input | 1 | Cipher result valid |
| ciph_result | input | 128 | Enciphered state |

## Verification
A wrong chaining state does not show until the run ends, and then the tag differs in every word read back. The bench therefore compares whole tags computed by its own model for aligned, split and partial messages. A wrong remaining-byte count shows sooner. Either the run ends early or late, which appears as a missing or extra stall at `dma_ready` and as status bit 0 rising in the wrong place. A lost error path appears as bit 31 staying clear while control bit 30 rises. The stall rule is watched on every cycle, so a single overlap of `ciph_req` and `dma_ready` is reported.

// File: rtl/cbcmac_pkg.sv
package cbcmac_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BLK_WORDS = 4;
  localparam int unsigned BLK_W     = WORD_W * BLK_WORDS;
  localparam int unsigned BLK_BYTES = BLK_W / 8;

  typedef enum logic [1:0] {
    DP_IDLE    = 2'd0,
    DP_COLLECT = 2'd1,
    DP_CIPHER  = 2'd2
  } dp_state_e;

  localparam logic [4:0] A_SEL   = 5'd0;
  localparam logic [4:0] A_KEY   = 5'd1;
  localparam logic [4:0] A_ISTAT = 5'd2;
  localparam logic [4:0] A_ICLR  = 5'd3;
  localparam logic [4:0] A_CTRL  = 5'd4;
  localparam logic [4:0] A_LENLO = 5'd5;
  localparam logic [4:0] A_LENHI = 5'd6;
  localparam logic [2:0] A_IV_HI  = 3'b010;
  localparam logic [2:0] A_TAG_HI = 3'b011;
  localparam logic [4:0] A_TAG_LAST = 5'd15;

  localparam logic [31:0] SEL_STREAM = 32'h0000_0002;

  // keep the n lowest bytes of a word, clear the rest
  function automatic logic [WORD_W-1:0] keep_bytes(logic [WORD_W-1:0] w, logic [2:0] n);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(n)) r[8*i +: 8] = w[8*i +: 8];
    end
    return r;
  endfunction

  // true when a byte count is not a whole number of blocks
  function automatic logic misaligned(logic [3:0] low_bits);
    return |low_bits;
  endfunction
endpackage

// File: rtl/cbcmac_keyctl.sv
module cbcmac_keyctl #(
  parameter int unsigned AREA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic [AREA_W-1:0] area_in,
  input  logic              key_done,
  input  logic              key_err,
  output logic              key_start,
  output logic [AREA_W-1:0] key_area,
  output logic              busy,
  output logic              fail_evt
);
  logic              busy_q;
  logic [AREA_W-1:0] area_q;

  assign key_start = load_wr && !busy_q;
  assign fail_evt  = busy_q && key_done && key_err;
  assign busy      = busy_q;
  assign key_area  = area_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      area_q <= '0;
    end else if (key_start) begin
      busy_q <= 1'b1;
      area_q <= area_in;
    end else if (busy_q && key_done) begin
      busy_q <= 1'b0;
    end
  end

  p_key_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_start |=> busy);
  p_key_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_done) |=> !busy);
endmodule

// File: rtl/cbcmac_datapath.sv
module cbcmac_datapath
  import cbcmac_pkg::*;
#(
  parameter int unsigned LEN_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              path_en,
  input  logic              start,
  input  logic              final_part,
  input  logic [LEN_W-1:0]  length,
  input  logic              iv_wr,
  input  logic [1:0]        iv_idx,
  input  logic [WORD_W-1:0] iv_data,
  input  logic              dma_valid,
  input  logic [WORD_W-1:0] dma_data,
  input  logic              dma_last,
  output logic              dma_ready,
  output logic              ciph_req,
  output logic [BLK_W-1:0]  ciph_data,
  input  logic              ciph_ack,
  input  logic [BLK_W-1:0]  ciph_result,
  output logic [BLK_W-1:0]  chain,
  output logic              ok_evt,
  output logic              err_evt
);
  dp_state_e         st_q;
  logic [LEN_W-1:0]  rem_q;
  logic [1:0]        widx_q;
  logic [BLK_W-1:0]  blk_q;
  logic [BLK_W-1:0]  chain_q;

  logic              take;
  logic [2:0]        nbytes;
  logic [LEN_W-1:0]  rem_next;
  logic [WORD_W-1:0] word_m;
  logic              blk_done;
  logic              early_end;
  logic              idle;
  logic              start_bad;
  logic              start_empty;
  logic              last_ack;

  assign idle        = (st_q == DP_IDLE);
  assign dma_ready   = (st_q == DP_COLLECT) && path_en;
  assign take        = dma_valid && dma_ready;
  assign nbytes      = (rem_q >= LEN_W'(4)) ? 3'd4 : rem_q[2:0];
  assign rem_next    = rem_q - LEN_W'(nbytes);
  assign word_m      = keep_bytes(dma_data, nbytes);
  assign blk_done    = (widx_q == 2'd3) || (rem_next == '0);
  assign early_end   = take && dma_last && (rem_next != '0);
  assign start_bad   = start && idle && !final_part && misaligned(length[3:0]);
  assign start_empty = start && idle && !start_bad && (length == '0);
  assign last_ack    = (st_q == DP_CIPHER) && ciph_ack && (rem_q == '0);

  assign ciph_req  = (st_q == DP_CIPHER);
  assign ciph_data = chain_q ^ blk_q;
  assign chain     = chain_q;
  assign ok_evt    = last_ack || start_empty;
  assign err_evt   = start_bad || early_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= DP_IDLE;
      rem_q   <= '0;
      widx_q  <= '0;
      blk_q   <= '0;
      chain_q <= '0;
    end else begin
      unique case (st_q)
        DP_IDLE: begin
          if (iv_wr) chain_q[int'(iv_idx)*WORD_W +: WORD_W] <= iv_data;
          if (start && !start_bad && !start_empty) begin
            st_q   <= DP_COLLECT;
            rem_q  <= length;
            widx_q <= '0;
            blk_q  <= '0;
          end
        end
        DP_COLLECT: begin
          if (take) begin
            blk_q[int'(widx_q)*WORD_W +: WORD_W] <= word_m;
            rem_q  <= rem_next;
            widx_q <= widx_q + 2'd1;
            if (early_end)     st_q <= DP_IDLE;
            else if (blk_done) st_q <= DP_CIPHER;
          end
        end
        DP_CIPHER: begin
          if (ciph_ack) begin
            chain_q <= ciph_result;
            blk_q   <= '0;
            widx_q  <= '0;
            st_q    <= (rem_q == '0) ? DP_IDLE : DP_COLLECT;
          end
        end
        default: st_q <= DP_IDLE;
      endcase
    end
  end

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ciph_req |-> !dma_ready);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ciph_req && !ciph_ack) |=> (ciph_req && $stable(ciph_data)));
  p_bad_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> !dma_ready);
  p_early_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    early_end |=> (!dma_ready && !ciph_req));
endmodule

// File: rtl/cbcmac_ctrl.sv
module cbcmac_ctrl
  import cbcmac_pkg::*;
#(
  parameter int unsigned LEN_W  = 40,
  parameter int unsigned AREA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              key_start,
  output logic [AREA_W-1:0] key_area,
  input  logic              key_done,
  input  logic              key_err,
  input  logic              dma_valid,
  input  logic [31:0]       dma_data,
  input  logic              dma_last,
  output logic              dma_ready,
  output logic              ciph_req,
  output logic [127:0]      ciph_data,
  input  logic              ciph_ack,
  input  logic [127:0]      ciph_result
);
  localparam int unsigned HI_W = LEN_W - 32;

  logic [31:0]      sel_q;
  logic [31:0]      lenlo_q;
  logic [HI_W-1:0]  lenhi_q;
  logic             final_q;
  logic             irq_done_q, irq_kerr_q, irq_err_q, ctx_q;

  logic             path_en;
  logic             wr_sel, wr_key, wr_iclr, wr_ctrl, wr_lo, wr_hi, wr_iv;
  logic             rd_tag_last;
  logic [LEN_W-1:0] run_len;
  logic [BLK_W-1:0] chain;
  logic             dp_ok, dp_err, key_busy, key_fail;

  assign wr_sel      = reg_wr && (reg_addr == A_SEL);
  assign wr_key      = reg_wr && (reg_addr == A_KEY);
  assign wr_iclr     = reg_wr && (reg_addr == A_ICLR);
  assign wr_ctrl     = reg_wr && (reg_addr == A_CTRL);
  assign wr_lo       = reg_wr && (reg_addr == A_LENLO);
  assign wr_hi       = reg_wr && (reg_addr == A_LENHI);
  assign wr_iv       = reg_wr && (reg_addr[4:2] == A_IV_HI);
  assign rd_tag_last = reg_rd && (reg_addr == A_TAG_LAST);
  assign path_en     = (sel_q == SEL_STREAM);
  assign run_len     = {reg_wdata[HI_W-1:0], lenlo_q};

  cbcmac_keyctl #(.AREA_W(AREA_W)) u_key (
    .clk(clk), .rst_n(rst_n), .load_wr(wr_key), .area_in(reg_wdata[AREA_W-1:0]),
    .key_done(key_done), .key_err(key_err), .key_start(key_start),
    .key_area(key_area), .busy(key_busy), .fail_evt(key_fail)
  );

  cbcmac_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .path_en(path_en), .start(wr_hi),
    .final_part(final_q), .length(run_len), .iv_wr(wr_iv),
    .iv_idx(reg_addr[1:0]), .iv_data(reg_wdata), .dma_valid(dma_valid),
    .dma_data(dma_data), .dma_last(dma_last), .dma_ready(dma_ready),
    .ciph_req(ciph_req), .ciph_data(ciph_data), .ciph_ack(ciph_ack),
    .ciph_result(ciph_result), .chain(chain), .ok_evt(dp_ok), .err_evt(dp_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= '0;
      lenlo_q    <= '0;
      lenhi_q    <= '0;
      final_q    <= 1'b0;
      irq_done_q <= 1'b0;
      irq_kerr_q <= 1'b0;
      irq_err_q  <= 1'b0;
      ctx_q      <= 1'b0;
    end else begin
      if (wr_sel)  sel_q   <= reg_wdata;
      if (wr_lo)   lenlo_q <= reg_wdata;
      if (wr_hi)   lenhi_q <= reg_wdata[HI_W-1:0];
      if (wr_ctrl) final_q <= reg_wdata[0];

      if (dp_ok || dp_err)                irq_done_q <= 1'b1;
      else if (wr_iclr && reg_wdata[0])   irq_done_q <= 1'b0;
      if (key_fail)                       irq_kerr_q <= 1'b1;
      else if (wr_iclr && reg_wdata[29])  irq_kerr_q <= 1'b0;
      if (dp_err)                         irq_err_q  <= 1'b1;
      else if (wr_iclr && reg_wdata[31])  irq_err_q  <= 1'b0;
      if (dp_ok)                          ctx_q      <= 1'b1;
      else if (rd_tag_last)               ctx_q      <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[4:2] == A_TAG_HI) begin
      reg_rdata = chain[int'(reg_addr[1:0])*WORD_W +: WORD_W];
    end else begin
      unique case (reg_addr)
        A_SEL:   reg_rdata = sel_q;
        A_KEY:   reg_rdata = {key_busy, {(31-AREA_W){1'b0}}, key_area};
        A_ISTAT: reg_rdata = {irq_err_q, 1'b0, irq_kerr_q, 28'd0, irq_done_q};
        A_CTRL:  reg_rdata = {1'b0, ctx_q, 29'd0, final_q};
        A_LENLO: reg_rdata = lenlo_q;
        A_LENHI: reg_rdata = 32'(lenhi_q);
        default: reg_rdata = '0;
      endcase
    end
  end

  p_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !path_en |-> !dma_ready);
  p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_ok || dp_err) |=> irq_done_q);
  p_ctx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tag_last && !dp_ok) |=> !ctx_q);
  p_err_no_ctx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dp_err |-> !dp_ok);
  p_kerr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_fail |=> irq_kerr_q);
endmodule

// File: tb/cbcmac_ctrl_tb.sv
module cbcmac_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         key_start;
  logic [3:0]   key_area;
  logic         key_done = 1'b0, key_err = 1'b0;
  logic         dma_valid = 1'b0, dma_last = 1'b0;
  logic [31:0]  dma_data = '0;
  logic         dma_ready;
  logic         ciph_req;
  logic [127:0] ciph_data;
  logic         ciph_ack;
  logic [127:0] ciph_result;

  int n_vec = 0, n_bad = 0, stall_bad = 0;
  logic mon_en = 1'b0;
  logic [31:0] q_exp[$];
  logic [31:0] q_mask[$];
  string       q_tag[$];
  logic [7:0]  msg_b[128];

  always #5 clk = ~clk;

  cbcmac_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .key_start(key_start),
    .key_area(key_area), .key_done(key_done), .key_err(key_err),
    .dma_valid(dma_valid), .dma_data(dma_data), .dma_last(dma_last),
    .dma_ready(dma_ready), .ciph_req(ciph_req), .ciph_data(ciph_data),
    .ciph_ack(ciph_ack), .ciph_result(ciph_result)
  );

  function automatic logic [127:0] ciph_f(logic [127:0] x);
    return {x[118:0], x[127:119]} ^ 128'h3c5a96e10f1e2d3c4b5a69788796a5b4;
  endfunction

  // expected tag: chain over n bytes from offset off, zero padded
  function automatic logic [127:0] mac_fn(logic [127:0] iv, int off, int n);
    logic [127:0] s;
    logic [127:0] b;
    s = iv;
    for (int k = 0; k * 16 < n; k++) begin
      b = '0;
      for (int j = 0; j < 16; j++)
        if (k * 16 + j < n) b[8*j +: 8] = msg_b[off + k * 16 + j];
      s = ciph_f(s ^ b);
    end
    return s;
  endfunction

  // fixed-latency cipher stand-in
  logic       pend;
  logic [1:0] lat;
  logic [127:0] cap;
  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; lat <= '0; cap <= '0; ciph_ack <= 1'b0; ciph_result <= '0;
    end else begin
      ciph_ack <= 1'b0;
      if (ciph_req && !pend && !ciph_ack) begin
        pend <= 1'b1; lat <= 2'd2; cap <= ciph_data;
      end else if (pend) begin
        if (lat == 2'd0) begin
          ciph_ack <= 1'b1; ciph_result <= ciph_f(cap); pend <= 1'b0;
        end else lat <= lat - 2'd1;
      end
    end
  end

  // R12 stall watch
  always @(negedge clk) if (rst_n && ciph_req && dma_ready) stall_bad++;

  // scoreboard monitor: pops expected read values
  always @(negedge clk) begin
    #2;
    if (reg_rd && mon_en && q_exp.size() > 0) begin
      logic [31:0] e, m;
      string t;
      e = q_exp.pop_front(); m = q_mask.pop_front(); t = q_tag.pop_front();
      n_vec++;
      if ((reg_rdata & m) !== (e & m)) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h (mask %h)", t, reg_rdata & m, e & m, m);
      end
    end
  end

  task automatic chk(string t, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_exp(logic [4:0] a, logic [31:0] e, logic [31:0] m, string t);
    q_exp.push_back(e); q_mask.push_back(m); q_tag.push_back(t);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; mon_en = 1'b1;
    @(negedge clk); reg_rd = 1'b0; mon_en = 1'b0;
  endtask

  task automatic rd_raw(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic setup(logic [127:0] iv, bit fin, int len);
    for (int k = 0; k < 4; k++) wr(5'(8 + k), iv[32*k +: 32]);
    wr(5'd4, {31'd0, fin});
    wr(5'd5, 32'(len));
    wr(5'd6, 32'd0);
  endtask

  task automatic send(int off, int n, bit last);
    int nw;
    nw = (n + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d;
      for (int i = 0; i < 4; i++)
        d[8*i +: 8] = (4 * w + i < n) ? msg_b[off + 4 * w + i] : 8'hEE;
      @(negedge clk); dma_valid = 1'b1; dma_data = d; dma_last = last && (w == nw - 1);
      #1;
      while (!dma_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk); dma_valid = 1'b0; dma_last = 1'b0;
  endtask

  task automatic check_tag(logic [127:0] e, string t);
    for (int k = 0; k < 4; k++) rd_exp(5'(12 + k), e[32*k +: 32], 32'hFFFFFFFF, t);
  endtask

  task automatic clear_all();
    wr(5'd3, 32'hA000_0001);
    for (int k = 12; k < 16; k++) begin
      logic [31:0] d;
      rd_raw(5'(k), d);
    end
  endtask

  logic [127:0] iv_a, exp_t, mid_t;

  initial begin
    for (int i = 0; i < 128; i++) msg_b[i] = 8'(i * 37 + 11);
    iv_a = 128'h00112233_44556677_8899aabb_ccddeeff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_exp(5'd2, 32'h0, 32'hFFFFFFFF, "R1 status");
    rd_exp(5'd4, 32'h0, 32'hFFFFFFFF, "R1 control");
    rd_exp(5'd12, 32'h0, 32'hFFFFFFFF, "R1 tag0");
    #1 chk("R1 dma_ready", {31'd0, dma_ready}, 32'd0);
    chk("R1 ciph_req", {31'd0, ciph_req}, 32'd0);

    // R3 key load handshake
    @(negedge clk); reg_wr = 1'b1; reg_addr = 5'd1; reg_wdata = 32'h3;
    #1 chk("R3 key_start pulse", {31'd0, key_start}, 32'd1);
    @(negedge clk); reg_wr = 1'b0;
    chk("R3 key_area", {28'd0, key_area}, 32'd3);
    rd_exp(5'd1, 32'h8000_0003, 32'hFFFFFFFF, "R3 busy");
    @(negedge clk); key_done = 1'b1;
    @(negedge clk); key_done = 1'b0;
    rd_exp(5'd1, 32'h0000_0003, 32'hFFFFFFFF, "R3 idle");
    rd_exp(5'd2, 32'h0, 32'h2000_0000, "R4 no key error");
    // R4 failing key load
    wr(5'd1, 32'h5);
    @(negedge clk); key_done = 1'b1; key_err = 1'b1;
    @(negedge clk); key_done = 1'b0; key_err = 1'b0;
    rd_exp(5'd2, 32'h2000_0000, 32'h2000_0000, "R4 key error bit");
    wr(5'd3, 32'h2000_0000);
    rd_exp(5'd2, 32'h0, 32'h2000_0000, "R4 key error cleared");

    // R2 gated path, then one aligned block
    wr(5'd0, 32'h0);
    setup(iv_a, 1'b1, 16);
    @(negedge clk); dma_valid = 1'b1; dma_data = 32'h1234_5678;
    for (int c = 0; c < 4; c++) begin
      #1 chk("R2 gated ready", {31'd0, dma_ready}, 32'd0);
      @(negedge clk);
    end
    dma_valid = 1'b0;
    rd_exp(5'd2, 32'h0, 32'h1, "R2 no completion while gated");
    wr(5'd0, 32'h2);
    send(0, 16, 1'b1);
    repeat (10) @(negedge clk);
    rd_exp(5'd2, 32'h1, 32'hA000_0001, "R8 done set");
    rd_exp(5'd4, 32'h4000_0000, 32'h4000_0000, "R9 ctx ready set");
    exp_t = mac_fn(iv_a, 0, 16);
    for (int k = 0; k < 3; k++) rd_exp(5'(12 + k), exp_t[32*k +: 32], 32'hFFFFFFFF, "R5 tag word");
    rd_exp(5'd4, 32'h4000_0000, 32'h4000_0000, "R9 ctx held after three words");
    rd_exp(5'd15, exp_t[127:96], 32'hFFFFFFFF, "R5 tag word 3");
    rd_exp(5'd4, 32'h0, 32'h4000_0000, "R9 ctx cleared by last word");
    wr(5'd3, 32'h1);
    rd_exp(5'd2, 32'h0, 32'h1, "R8 done cleared");

    // R5 three blocks in one run
    setup(iv_a, 1'b1, 48);
    send(16, 48, 1'b1);
    repeat (10) @(negedge clk);
    check_tag(mac_fn(iv_a, 16, 48), "R5 three-block tag");
    rd_exp(5'd2, 32'h1, 32'hA000_0001, "R5 clean status");
    clear_all();

    // R6 + R7 split message: 32 aligned bytes, then 21 bytes
    setup(iv_a, 1'b0, 32);
    send(0, 32, 1'b1);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d;
      rd_raw(5'(12 + k), d);
      mid_t[32*k +: 32] = d;
    end
    chk("R6 intermediate tag", mid_t[31:0], mac_fn(iv_a, 0, 32) & 32'hFFFFFFFF);
    wr(5'd3, 32'h1);
    setup(mid_t, 1'b1, 21);
    send(32, 21, 1'b1);
    repeat (10) @(negedge clk);
    check_tag(mac_fn(iv_a, 0, 53), "R6 R7 resumed tag");
    rd_exp(5'd2, 32'h1, 32'hA000_0001, "R7 partial ok");
    clear_all();

    // R7 short final part with junk bytes in the word
    setup(iv_a, 1'b1, 5);
    send(70, 5, 1'b1);
    repeat (10) @(negedge clk);
    check_tag(mac_fn(iv_a, 70, 5), "R7 zero pad");
    clear_all();

    // R10 stream ends early
    setup(iv_a, 1'b1, 32);
    send(0, 8, 1'b1);
    repeat (4) @(negedge clk);
    rd_exp(5'd2, 32'h8000_0001, 32'hA000_0001, "R10 error and done");
    rd_exp(5'd4, 32'h0, 32'h4000_0000, "R10 no ctx ready");
    #1 chk("R10 ready dropped", {31'd0, dma_ready}, 32'd0);
    clear_all();

    // R11 non-final misaligned length
    setup(iv_a, 1'b0, 20);
    @(negedge clk); dma_valid = 1'b1; dma_data = 32'h0;
    #1 chk("R11 no word accepted", {31'd0, dma_ready}, 32'd0);
    @(negedge clk); dma_valid = 1'b0;
    rd_exp(5'd2, 32'h8000_0001, 32'hA000_0001, "R11 error and done");
    rd_exp(5'd4, 32'h0, 32'h4000_0000, "R11 no ctx ready");
    clear_all();

    chk("R12 no accept during cipher", 32'(stall_bad), 32'd0);
    if (q_exp.size() != 0) chk("scoreboard drained", 32'(q_exp.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule